// File: doc/BRIEF.md
# Zeroizing Hash Message Register Bank

This block is a memory-mapped buffer that sits between a bus master and a hash engine. Software fills a bank of sixteen 32-bit message words over an AXI4-Lite slave port. It then writes a start bit. When every word has been written and the start arrives, the bank presents the whole 512-bit block to the engine on a valid/ready port and holds it there until the engine takes it.

Once the engine has taken the block, the copy in the bank has no further use. The bank therefore wipes every word and its load-tracking mask. A later read of any word returns zero, and a fresh start cannot reuse stale contents.

The same wipe can be triggered in three other ways: the global active-low reset, a separate active-high peripheral reset, and a zeroize input meant for tamper detection or a change of owner. Each of these works at any time. While a handoff is pending, the words are frozen. Bus writes to them are refused, and bus reads of them return zero.

Top module: `hash_msg_bank`

## Requirements
- R1: Message word i (0 to 15) sits at byte address 4*i. A write stores only the bytes whose wstrb bit is set, and a read of that address returns the stored word. A write to the status address (0x44) changes nothing, and status reads back 0 when the bank is idle with no flags set.
- R2: A write to the control address 0x40 with wdata bit 0 and wstrb bit 0 set is a start request. If all sixteen words have been written since the last wipe, blk_valid rises and blk_data carries word i in bits [32*i+31:32*i]. Status bit 0 (busy) then reads 1 and status bit 2 (error) reads 0.
- R3: A start request while any word has not been written leaves blk_valid low and sets status bit 2 (error).
- R4: While blk_valid is high and blk_ready is low, blk_valid stays high and blk_data stays unchanged.
- R5: After a cycle with blk_valid and blk_ready both high, blk_valid is low, every word reads 0, and status bit 1 (done) is set. The written mask is also cleared, so a new start request without reloading sets the error bit.
- R6: While busy, a write to a message word is not stored and gets bresp SLVERR (2'b10). A read of a message word returns 0.
- R7: One clock edge with zeroize_i high clears all words, the written mask, a pending handoff (blk_valid low) and the error and done flags.
- R8: rst_n low, or periph_rst high at a clock edge, clears all words and the status flags. Either reset alone is enough.
- R9: When no response is pending, awready and wready go high while awvalid and wvalid are both high. The write response is valid on the next cycle. A read address is accepted when no read data is pending, and rdata is valid on the next cycle. A response holds until the master takes it, and accepted non-error accesses answer OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| periph_rst | input | 1 | Peripheral reset, active high, synchronous |
| zeroize_i | input | 1 | Wipe request from tamper or owner-change logic |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 8 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 8 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| blk_valid | output | 1 | Message block offered to engine |
| blk_ready | input | 1 | Engine accepts block |
| blk_data | output | 512 | Message block, word i at bits 32*i upward |

## Verification
The bench holds blk_ready low for several cycles after a start. A bank that dropped valid or let a write slip into a frozen word would show up as a changed blk_data or an OKAY response. After the handshake it reads every word back and issues a start without reloading. A bank that kept its data or mask would return old words or hand off stale data instead of flagging an error. The wipe paths are also tested: zeroize fired while a handoff is pending and after a partial load, plus both resets on their own. A wipe that missed the mask or the pending valid would show up as an accepted start or a lingering blk_valid.

// File: rtl/hash_msg_bank.sv
module hash_msg_bank #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter logic [7:0] CTRL_OFF = 8'h40,
  parameter logic [7:0] STAT_OFF = 8'h44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                periph_rst,
  input  logic                zeroize_i,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [AW-1:0]       s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DW-1:0]       s_wdata,
  input  logic [DW/8-1:0]     s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [AW-1:0]       s_araddr,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DW-1:0]       s_rdata,
  output logic [1:0]          s_rresp,
  output logic                blk_valid,
  input  logic                blk_ready,
  output logic [WORDS*DW-1:0] blk_data
);
  localparam int SB   = DW / 8;
  localparam int IDXW = $clog2(WORDS);
  localparam int BLKW = WORDS * DW;
  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_ERR = 2'b10;

  logic [DW-1:0]    words [WORDS];
  logic [BLKW-1:0]  msg_flat;
  logic [WORDS-1:0] wr_mask;
  logic busy_q, done_q, err_q;

  logic wipe, hs, wr_fire, wr_is_data, wr_is_ctrl, data_we, start_req, full;
  logic rd_fire, rd_is_data, rd_is_stat;
  logic [IDXW-1:0] widx, ridx;
  logic [DW-1:0] rd_mux;

  assign wipe       = zeroize_i || periph_rst;
  assign hs         = busy_q && blk_ready;
  assign full       = &wr_mask;

  assign wr_fire    = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready  = wr_fire;
  assign s_wready   = wr_fire;
  assign wr_is_data = (s_awaddr[1:0] == 2'b00) && (s_awaddr[AW-1:2] < WORDS);
  assign wr_is_ctrl = (s_awaddr == CTRL_OFF);
  assign widx       = s_awaddr[IDXW+1:2];
  assign data_we    = wr_fire && wr_is_data && !busy_q;
  assign start_req  = wr_fire && wr_is_ctrl && s_wdata[0] && s_wstrb[0] && !busy_q;

  assign s_arready  = !s_rvalid;
  assign rd_fire    = s_arvalid && s_arready;
  assign rd_is_data = (s_araddr[1:0] == 2'b00) && (s_araddr[AW-1:2] < WORDS);
  assign rd_is_stat = (s_araddr == STAT_OFF);
  assign ridx       = s_araddr[IDXW+1:2];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words[g] <= '0;
        end else if (wipe || hs) begin
          words[g] <= '0;
        end else if (data_we && widx == IDXW'(g)) begin
          for (int b = 0; b < SB; b++)
            if (s_wstrb[b]) words[g][8*b +: 8] <= s_wdata[8*b +: 8];
        end
      end
      assign msg_flat[g*DW +: DW] = words[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_mask <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (wipe) begin
      wr_mask <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (hs) begin
      wr_mask <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
    end else begin
      if (data_we && |s_wstrb) wr_mask[widx] <= 1'b1;
      if (start_req) begin
        err_q <= !full;
        if (full) begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_is_data && !busy_q) rd_mux = words[ridx];
    else if (rd_is_stat)       rd_mux = DW'({err_q, done_q, busy_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OK;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (periph_rst) begin
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OK;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_fire) begin
        s_bvalid <= 1'b1;
        s_bresp  <= (wr_is_data && busy_q) ? RESP_ERR : RESP_OK;
      end else if (s_bready) begin
        s_bvalid <= 1'b0;
      end
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_mux;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
        s_rdata  <= '0;
      end
    end
  end

  assign s_rresp   = RESP_OK;
  assign blk_valid = busy_q;
  assign blk_data  = busy_q ? msg_flat : '0;
endmodule

module hash_msg_bank_chk #(
  parameter int WORDS = 16,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                periph_rst,
  input logic                zeroize_i,
  input logic                blk_valid,
  input logic                blk_ready,
  input logic [WORDS*DW-1:0] blk_data,
  input logic [WORDS*DW-1:0] msg_flat,
  input logic [WORDS-1:0]    wr_mask,
  input logic                s_rvalid,
  input logic                s_rready,
  input logic [DW-1:0]       s_rdata,
  input logic                s_bvalid,
  input logic                s_bready,
  input logic [1:0]          s_bresp
);
  p_full_before_handoff_r2: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    $rose(blk_valid) |-> $past(wr_mask) == '1);

  p_hold_block_r4: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    blk_valid && !blk_ready && !zeroize_i |=> blk_valid && $stable(blk_data));

  p_wipe_after_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    blk_valid && blk_ready |=> !blk_valid && msg_flat == '0 && wr_mask == '0);

  p_zeroize_clears_r7: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    zeroize_i |=> !blk_valid && msg_flat == '0 && wr_mask == '0);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  p_bresp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || periph_rst)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
endmodule

bind hash_msg_bank hash_msg_bank_chk #(.WORDS(WORDS), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .periph_rst(periph_rst), .zeroize_i(zeroize_i),
  .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
  .msg_flat(msg_flat), .wr_mask(wr_mask),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
);

// File: tb/hash_msg_bank_tb_top.sv
module hash_msg_bank_tb_top;
  logic clk = 0;
  logic rst_n = 0, periph_rst = 0, zeroize_i = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [7:0] awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [3:0] wstrb = 0;
  logic [1:0] bresp, rresp;
  logic blk_valid, blk_ready = 0;
  logic [511:0] blk_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hash_msg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .periph_rst(periph_rst), .zeroize_i(zeroize_i),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data)
  );

  localparam logic [75:0] VEC [6] = '{
    {8'h00, 32'hDEADBEEF, 4'hF, 32'hDEADBEEF},
    {8'h04, 32'h12345678, 4'h3, 32'h00005678},
    {8'h3C, 32'hA5A5A5A5, 4'hF, 32'hA5A5A5A5},
    {8'h3C, 32'h00FF0000, 4'h4, 32'hA5FFA5A5},
    {8'h20, 32'hCAFEF00D, 4'h8, 32'hCA000000},
    {8'h44, 32'hFFFFFFFF, 4'hF, 32'h00000000}
  };

  function automatic logic [31:0] pat(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        output logic [1:0] r);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1 chk("R9 awready", {31'b0, awready && wready}, 1);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R9 bvalid", {31'b0, bvalid}, 1);
    r = bresp;
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    #1 chk("R9 arready", {31'b0, arready}, 1);
    @(negedge clk);
    arvalid = 0;
    chk("R9 rvalid", {31'b0, rvalid}, 1);
    d = rdata;
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic load_all();
    logic [1:0] r;
    for (int i = 0; i < 16; i++) axi_wr(8'(4 * i), pat(i), 4'hF, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] r;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk("R8 reset blk_valid", {31'b0, blk_valid}, 0);
    axi_rd(8'h44, d); chk("R8 reset status", d, 0);
    axi_rd(8'h00, d); chk("R8 reset word0", d, 0);

    for (int v = 0; v < 6; v++) begin
      axi_wr(VEC[v][75:68], VEC[v][67:36], VEC[v][35:32], r);
      chk("R9 bresp okay", {30'b0, r}, 0);
      axi_rd(VEC[v][75:68], d);
      chk("R1 readback", d, VEC[v][31:0]);
    end

    @(negedge clk) periph_rst = 1;
    @(negedge clk) periph_rst = 0;
    axi_rd(8'h00, d); chk("R8 periph_rst word0", d, 0);
    axi_rd(8'h3C, d); chk("R8 periph_rst word15", d, 0);

    axi_wr(8'h00, 32'h1111_2222, 4'hF, r);
    axi_wr(8'h40, 32'h1, 4'hF, r);
    chk("R3 no valid", {31'b0, blk_valid}, 0);
    axi_rd(8'h44, d); chk("R3 error flag", d, 32'h4);

    load_all();
    axi_wr(8'h40, 32'h1, 4'hF, r);
    chk("R2 valid", {31'b0, blk_valid}, 1);
    for (int i = 0; i < 16; i++) chk("R2 block word", blk_data[32*i +: 32], pat(i));
    axi_rd(8'h44, d); chk("R2 status busy", d, 32'h1);
    axi_rd(8'h0C, d); chk("R6 read while busy", d, 0);
    axi_wr(8'h0C, 32'hFFFF_FFFF, 4'hF, r);
    chk("R6 slverr", {30'b0, r}, 2'b10);
    repeat (4) @(negedge clk);
    chk("R4 valid held", {31'b0, blk_valid}, 1);
    chk("R4 word3 unchanged", blk_data[96 +: 32], pat(3));
    chk("R4 word15 unchanged", blk_data[480 +: 32], pat(15));

    @(negedge clk) blk_ready = 1;
    @(negedge clk) blk_ready = 0;
    chk("R5 valid dropped", {31'b0, blk_valid}, 0);
    for (int i = 0; i < 16; i++) begin
      axi_rd(8'(4 * i), d);
      chk("R5 word wiped", d, 0);
    end
    axi_rd(8'h44, d); chk("R5 done flag", d, 32'h2);
    axi_wr(8'h40, 32'h1, 4'hF, r);
    chk("R5 no stale handoff", {31'b0, blk_valid}, 0);
    axi_rd(8'h44, d); chk("R5 mask cleared", d, 32'h6);

    load_all();
    axi_wr(8'h40, 32'h1, 4'hF, r);
    chk("R7 pre valid", {31'b0, blk_valid}, 1);
    @(negedge clk) zeroize_i = 1;
    @(negedge clk) zeroize_i = 0;
    chk("R7 valid dropped", {31'b0, blk_valid}, 0);
    axi_rd(8'h00, d); chk("R7 word0", d, 0);
    axi_rd(8'h3C, d); chk("R7 word15", d, 0);
    axi_rd(8'h44, d); chk("R7 status clear", d, 0);

    axi_wr(8'h00, 32'h5555_AAAA, 4'hF, r);
    axi_wr(8'h40, 32'h1, 4'hF, r);
    @(negedge clk) zeroize_i = 1;
    @(negedge clk) zeroize_i = 0;
    axi_rd(8'h44, d); chk("R7 error cleared", d, 0);
    for (int i = 1; i < 16; i++) axi_wr(8'(4 * i), pat(i), 4'hF, r);
    axi_wr(8'h40, 32'h1, 4'hF, r);
    chk("R7 mask wiped no valid", {31'b0, blk_valid}, 0);
    axi_rd(8'h44, d); chk("R7 mask wiped error", d, 32'h4);

    axi_wr(8'h14, 32'h7777_8888, 4'hF, r);
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    axi_rd(8'h14, d); chk("R8 rst_n word5", d, 0);
    axi_rd(8'h44, d); chk("R8 rst_n status", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule